// File: doc/BRIEF.md
# Buffered Serial Peripheral Master with Four Select Lines

This block drives a four-wire serial peripheral bus as bus master. Software fills a transmit queue through a small register port and then sets a start flag. The shift engine then sends every queued word, one after another, while it holds the chosen select line active. Each word that arrives on the return line goes into a receive queue. Software drains that queue by reading the receive-data register until the status shows it is empty. The word length, the select channel and the serial clock rate come from the control register. Each channel has its own clock phase, clock polarity and select polarity in the config register, so devices with different bus modes can share one controller.

Two level interrupt causes are provided: the transmit queue is empty, and the receive queue holds data. Software can run the block by interrupt or by polling. The start flag clears itself once the last queued word has finished shifting and the select line has been released, so software can also poll the control register to see when the block is done.

Register word addresses on `bus_addr`:
- 0: receive data. A read pops one word. A read when the queue is empty returns 0.
- 1: transmit data. A write pushes one word.
- 2: control. Bit 0 is enable. Bit 2 is start, and it reads back as 1 while an exchange is pending or running. Bits 7:4 are the per-channel master flags. Bits 11:8 are the post-scaler P. Bits 15:12 are the pre-scaler Q. Bits 19:18 select the channel. Bits 24:20 hold the word length minus 1.
- 3: config. For channel n, bit n is clock phase, bit n+4 is clock polarity and bit n+12 makes the select line active-high.
- 4: interrupt enable. Bit 0 enables the transmit-empty cause and bit 3 enables the receive-ready cause.
- 5: status. Bit 0 reads 1 when the transmit queue is empty. Bit 3 reads 1 when the receive queue is not empty.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, every `ss_n` bit is 1, `sclk` and `mosi` are 0, `irq` is 0 and the status register reads 1.
- R2: A word of L bits (L = control[24:20] + 1, from 1 to 32) leaves on `mosi` most significant bit first, and exactly L bits are sampled. The received word reads back right-aligned with zeros above bit L-1.
- R3: The transmit queue holds 64 words. A write to the transmit-data register while the queue is full is discarded, and the words already queued go out in order.
- R4: A read of the receive-data register while the receive queue is empty returns 0 and leaves the queue empty.
- R5: Writing 1 to control bit 2 starts an exchange of the queued words. The bit reads 1 until the transmit queue is empty and the last word has completed, and by the time it reads 0 the select line is already inactive.
- R6: The selected channel's polarity bit sets the idle level of `sclk`. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge of each bit.
- R7: During an exchange, only `ss_n[channel]` is at its active level, which is 1 when config bit channel+12 is set and 0 otherwise. All other select outputs stay at their inactive level.
- R8: Each `sclk` half period lasts (Q+1)·2^P clock cycles.
- R9: Status bit 3 is 1 exactly while the receive queue holds a word. Status bit 0 is 1 exactly while the transmit queue is empty.
- R10: `irq` is 1 when (enable bit 0 and transmit queue empty) or (enable bit 3 and receive queue not empty).
- R11: While control bit 0 is 0, a pending start flag does not begin an exchange and the queued words stay queued. Setting bit 0 later starts the exchange.
- R12: Words that are queued while an exchange is running are sent in the same burst, and the select line stays asserted between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Select lines, one per channel |

## Verification
Two functions can land in the same cycle. The first pair is a software push into the transmit queue and the engine's pop of the next word. The second pair is a software write of the start flag and its self-clear. The bench provokes the first pair by writing 5-bit words on every clock cycle while a fast exchange drains the queue. It then judges the result by reading back all sixteen looped-back words in order, and by checking that the select line was released exactly once. Random exchanges, with mixed modes, lengths, channels and divider settings, are checked against a bus-side monitor that samples `mosi` on the edge the requirements call for.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
   typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_FINISH} eng_state_t;

   localparam logic [2:0] REG_RXD = 3'd0;
   localparam logic [2:0] REG_TXD = 3'd1;
   localparam logic [2:0] REG_CTL = 3'd2;
   localparam logic [2:0] REG_CFG = 3'd3;
   localparam logic [2:0] REG_IEN = 3'd4;
   localparam logic [2:0] REG_STA = 3'd5;

   localparam int CTL_EN    = 0;
   localparam int CTL_XCH   = 2;
   localparam int CTL_POST  = 8;
   localparam int CTL_PRE   = 12;
   localparam int CTL_CH    = 18;
   localparam int CTL_BLEN  = 20;
   localparam int CFG_PHA   = 0;
   localparam int CFG_POL   = 4;
   localparam int CFG_SSHI  = 12;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("spi_fm_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == $past(count)));
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
   import spi_fm_pkg::*;
#(
   parameter int DW   = 32,
   parameter int CHW  = 2,
   parameter int DIVW = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              xch,
   input  logic              tx_empty,
   input  logic [DW-1:0]     tx_word,
   input  logic [$clog2(DW)-1:0] len_m1,
   input  logic [DIVW-1:0]   half,
   input  logic              cpha,
   input  logic [CHW-1:0]    ch_sel,
   input  logic              miso,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [DW-1:0]     rx_word,
   output logic              sclk_raw,
   output logic              mosi,
   output logic              cs_act,
   output logic [CHW-1:0]    cs_ch,
   output logic              done
);
   localparam int LW = $clog2(DW);

   eng_state_t    state;
   logic [DIVW-1:0] cnt;
   logic [LW+1:0] eidx;
   logic [DW-1:0] shreg, rxreg, aligned;
   logic [LW:0]   len, shamt;
   logic          start, capture;

   assign len     = {1'b0, len_m1} + 1'b1;
   assign shamt   = (LW+1)'(DW) - len;
   assign aligned = tx_word << shamt;
   assign start   = en && xch && !tx_empty && (state != ENG_SHIFT);
   assign tx_pop  = start;
   assign done    = (state == ENG_IDLE) && en && xch && tx_empty;
   assign rx_push = (state == ENG_FINISH);
   assign rx_word = rxreg;
   assign capture = (~eidx[0]) ^ cpha;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         cnt      <= '0;
         eidx     <= '0;
         shreg    <= '0;
         rxreg    <= '0;
         sclk_raw <= 1'b0;
         mosi     <= 1'b0;
         cs_act   <= 1'b0;
         cs_ch    <= '0;
      end else begin
         case (state)
            ENG_SHIFT: begin
               if (cnt == half - 1'b1) begin
                  cnt <= '0;
                  if (eidx == {len, 1'b0}) begin
                     state <= ENG_FINISH;
                  end else begin
                     sclk_raw <= ~sclk_raw;
                     eidx     <= eidx + 1'b1;
                     if (capture) begin
                        rxreg <= {rxreg[DW-2:0], miso};
                     end else begin
                        mosi  <= shreg[DW-1];
                        shreg <= shreg << 1;
                     end
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (start) begin
                  state  <= ENG_SHIFT;
                  cnt    <= '0;
                  eidx   <= '0;
                  rxreg  <= '0;
                  cs_act <= 1'b1;
                  cs_ch  <= ch_sel;
                  if (!cpha) begin
                     mosi  <= aligned[DW-1];
                     shreg <= aligned << 1;
                  end else begin
                     mosi  <= 1'b0;
                     shreg <= aligned;
                  end
               end else if (state == ENG_FINISH) begin
                  state  <= ENG_IDLE;
                  cs_act <= 1'b0;
                  mosi   <= 1'b0;
               end
            end
         endcase
      end
   end

   p_sclk_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !sclk_raw);
   p_cs_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_SHIFT) |-> cs_act);
   p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_IDLE && !en) |=> (state == ENG_IDLE));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_fm_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int NCH   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [2:0]     bus_addr,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic           irq,
   output logic           sclk,
   output logic           mosi,
   input  logic           miso,
   output logic [NCH-1:0] ss_n
);
   localparam int DW   = 32;
   localparam int LW   = $clog2(DW);
   localparam int CHW  = 2;
   localparam int DIVW = 20;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("spi_fifo_master: NCH must be 1 to 4");
   end

   logic [31:0]   ctrl_q, cfg_q, ien_q;
   logic          xch_q;
   logic          tx_push, tx_pop, tx_empty, tx_full;
   logic          rx_push, rx_pop, rx_empty, rx_full;
   logic [DW-1:0] tx_word, rx_in, rx_out;
   logic [CHW-1:0] ch, cs_ch;
   logic          cs_act, done, sclk_raw, cpha, cpol;
   logic [4:0]    pre_p1;
   logic [DIVW-1:0] half;

   assign ch      = ctrl_q[CTL_CH +: CHW];
   assign cpha    = cfg_q[CFG_PHA + int'(ch)];
   assign cpol    = cfg_q[CFG_POL + int'(ch)];
   assign pre_p1  = {1'b0, ctrl_q[CTL_PRE +: 4]} + 5'd1;
   assign half    = {{(DIVW-5){1'b0}}, pre_p1} << ctrl_q[CTL_POST +: 4];
   assign tx_push = bus_wr && (bus_addr == REG_TXD);
   assign rx_pop  = bus_rd && (bus_addr == REG_RXD);
   assign sclk    = sclk_raw ^ cpol;
   assign irq     = (ien_q[0] && tx_empty) || (ien_q[3] && !rx_empty);

   spi_fm_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
      .clk, .rst_n, .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
      .rdata(tx_word), .empty(tx_empty), .full(tx_full));

   spi_fm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
      .clk, .rst_n, .push(rx_push), .wdata(rx_in), .pop(rx_pop),
      .rdata(rx_out), .empty(rx_empty), .full(rx_full));

   spi_fm_engine #(.DW(DW), .CHW(CHW), .DIVW(DIVW)) u_eng (
      .clk, .rst_n, .en(ctrl_q[CTL_EN]), .xch(xch_q), .tx_empty,
      .tx_word, .len_m1(ctrl_q[CTL_BLEN +: LW]), .half, .cpha,
      .ch_sel(ch), .miso, .tx_pop, .rx_push, .rx_word(rx_in),
      .sclk_raw, .mosi, .cs_act, .cs_ch, .done);

   for (genvar i = 0; i < NCH; i++) begin : g_ss
      always_comb begin
         if (cs_act && cs_ch == CHW'(i)) ss_n[i] = cfg_q[CFG_SSHI + i];
         else                            ss_n[i] = ~cfg_q[CFG_SSHI + i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         cfg_q     <= '0;
         ien_q     <= '0;
         xch_q     <= 1'b0;
         bus_rdata <= '0;
      end else begin
         if (bus_wr && bus_addr == REG_CTL) begin
            ctrl_q <= bus_wdata & ~(32'd1 << CTL_XCH);
         end
         if (bus_wr && bus_addr == REG_CFG) cfg_q <= bus_wdata;
         if (bus_wr && bus_addr == REG_IEN) ien_q <= bus_wdata;
         if (bus_wr && bus_addr == REG_CTL && bus_wdata[CTL_XCH]) xch_q <= 1'b1;
         else if (done)                                           xch_q <= 1'b0;
         if (bus_rd) begin
            case (bus_addr)
               REG_RXD: bus_rdata <= rx_empty ? '0 : rx_out;
               REG_CTL: bus_rdata <= ctrl_q | (32'(xch_q) << CTL_XCH);
               REG_CFG: bus_rdata <= cfg_q;
               REG_IEN: bus_rdata <= ien_q;
               REG_STA: bus_rdata <= {28'd0, !rx_empty, tx_full, rx_full, tx_empty};
               default: bus_rdata <= '0;
            endcase
         end
      end
   end

   p_xch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xch_q) |-> !cs_act);
   p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ss_n ^ ~cfg_q[CFG_SSHI +: NCH]));
endmodule

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sclk, mosi, miso;
   logic [3:0]  ss_n;

   int checks = 0, fails = 0, cycles = 0;
   logic        m_cpol = 0, m_cpha = 0, prev_sclk = 0, prev_ss0 = 1;
   logic [31:0] mon_word = 0;
   int          mon_bits = 0, run = 0, run_max = 0, ss0_rises = 0;

   always #4 clk = ~clk;
   assign miso = mosi;

   spi_fifo_master uut (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
      .irq, .sclk, .mosi, .miso, .ss_n);

   function automatic logic [31:0] lmask(input int len);
      return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
   endfunction

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         summary();
      end
   end

   always @(negedge clk) begin
      if (sclk != prev_sclk) begin
         if ((sclk != m_cpol) ^ m_cpha) begin
            mon_word = {mon_word[30:0], mosi};
            mon_bits++;
         end
      end
      if (sclk != m_cpol) run++;
      else begin
         if (run > run_max) run_max = run;
         run = 0;
      end
      if (ss_n[0] && !prev_ss0) ss0_rises++;
      prev_ss0  = ss_n[0];
      prev_sclk = sclk;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [2:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #2;
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_done();
      logic [31:0] r;
      for (int k = 0; k < 20000; k++) begin
         brd(3'd2, r);
         if (!r[2]) return;
      end
      chk("R5 start flag never cleared", 32'd1, 32'd0);
   endtask

   task automatic mon_clear(input int cpol, input int cpha);
      m_cpol = cpol[0]; m_cpha = cpha[0];
      mon_word = 0; mon_bits = 0; run = 0; run_max = 0;
   endtask

   function automatic logic [31:0] ctl_word(input int ch, input int len,
                                            input int pre, input int post);
      return 32'h1 | 32'hF0 | (32'(ch) << 18) | (32'(len - 1) << 20)
             | (32'(pre) << 12) | (32'(post) << 8);
   endfunction

   task automatic xfer(input int ch, input int cpha, input int cpol, input int csh,
                       input int len, input int pre, input int post,
                       input logic [31:0] data);
      logic [31:0] r, ctl;
      ctl = ctl_word(ch, len, pre, post);
      bwr(3'd3, (32'(cpha) << ch) | (32'(cpol) << (ch + 4)) | (32'(csh) << (ch + 12)));
      bwr(3'd2, ctl);
      bwr(3'd1, data);
      mon_clear(cpol, cpha);
      bwr(3'd2, ctl | 32'h4);
      @(posedge clk); #2;
      chk("R7 active select", 32'(ss_n), (4'hF & ~(4'd1 << ch)) | (4'(csh) << ch));
      wait_done();
      chk("R5 select released at clear", 32'(ss_n[ch]), 32'(!csh[0]));
      chk("R6 sclk idle level", 32'(sclk), 32'(cpol));
      chk("R2 bit count", 32'(mon_bits), 32'(len));
      chk("R2 R6 msb-first bits on mosi", mon_word & lmask(len), data & lmask(len));
      chk("R8 half period", 32'(run_max), 32'((pre + 1) << post));
      brd(3'd0, r);
      chk("R2 right-aligned readback", r, data & lmask(len));
   endtask

   initial begin
      logic [31:0] r;
      int unused_seed;
      unused_seed = $urandom(20240611);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ss_n reset", 32'(ss_n), 32'hF);
      chk("R1 sclk reset", 32'(sclk), 0);
      chk("R1 mosi reset", 32'(mosi), 0);
      chk("R1 irq reset", 32'(irq), 0);
      @(posedge clk); #2;
      brd(3'd5, r);
      chk("R1 status reset", r, 32'h1);

      // R10 interrupt causes
      bwr(3'd4, 32'h1);
      chk("R10 tx-empty irq", 32'(irq), 1);
      bwr(3'd4, 32'h8);
      chk("R10 rx irq idle", 32'(irq), 0);

      // directed corner lengths
      xfer(0, 0, 0, 0, 1, 0, 0, 32'h1);
      xfer(3, 1, 1, 1, 32, 1, 1, 32'hA5C3_0F96);
      xfer(2, 1, 0, 0, 17, 2, 1, 32'h0001_B00D);

      // R9/R10 with a word left in the receive queue
      xfer(1, 0, 1, 0, 8, 0, 0, 32'h5A);
      bwr(3'd1, 32'h3C);
      bwr(3'd2, ctl_word(1, 8, 0, 0) | 32'h4);
      wait_done();
      chk("R10 rx-ready irq", 32'(irq), 1);
      brd(3'd5, r);
      chk("R9 status rx ready", r & 32'h9, 32'h9);
      brd(3'd0, r);
      chk("R2 word after status", r, 32'h3C);
      chk("R10 irq drops after drain", 32'(irq), 0);

      // R4 read from empty receive queue
      brd(3'd0, r);
      chk("R4 empty read value", r, 0);
      brd(3'd5, r);
      chk("R4 R9 still empty", r & 32'h8, 0);

      // R11 start while disabled
      bwr(3'd3, 32'h0);
      bwr(3'd2, ctl_word(0, 8, 0, 0) & ~32'h1 | 32'h4);
      bwr(3'd1, 32'h77);
      repeat (40) @(posedge clk);
      #2;
      chk("R11 no select while disabled", 32'(ss_n), 32'hF);
      brd(3'd5, r);
      chk("R11 word stays queued", r & 32'h1, 0);
      mon_clear(0, 0);
      bwr(3'd2, ctl_word(0, 8, 0, 0));
      wait_done();
      brd(3'd0, r);
      chk("R11 exchange after enable", r, 32'h77);

      // R3 fill past the queue size
      bwr(3'd2, ctl_word(0, 8, 0, 0));
      for (int i = 0; i < 65; i++) bwr(3'd1, 32'(i));
      brd(3'd5, r);
      chk("R9 tx not empty", r & 32'h1, 0);
      bwr(3'd2, ctl_word(0, 8, 0, 0) | 32'h4);
      wait_done();
      for (int i = 0; i < 64; i++) begin
         brd(3'd0, r);
         chk("R3 queued order", r, 32'(i));
      end
      brd(3'd0, r);
      chk("R3 R4 dropped word absent", r, 0);

      // R12 streaming: pushes collide with engine pops
      mon_clear(0, 0);
      ss0_rises = 0;
      bwr(3'd2, ctl_word(0, 5, 0, 0));
      bwr(3'd1, 32'd0);
      bwr(3'd2, ctl_word(0, 5, 0, 0) | 32'h4);
      for (int i = 1; i < 16; i++) bwr(3'd1, 32'(i));
      wait_done();
      chk("R12 one release per burst", 32'(ss0_rises), 1);
      for (int i = 0; i < 16; i++) begin
         brd(3'd0, r);
         chk("R12 streamed word", r, 32'(i));
      end

      // random mixes
      for (int n = 0; n < 24; n++) begin
         xfer($urandom_range(3), $urandom_range(1), $urandom_range(1),
              $urandom_range(1), $urandom_range(32, 1), $urandom_range(3),
              $urandom_range(2), $urandom);
      end
      summary();
   end
endmodule